// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a raster display from a set of compare registers that software programs. Each axis has a 10-bit position counter. The counter is compared with six programmed values: period, sync width, border begin, display begin, display finish and border finish. A match sets a sticky event flag, and the flags together give the axis phase. The horizontal counter advances on each enabled tick. The vertical counter advances once each time the horizontal counter restarts.

A single 32-bit write word carries both a target code and a value. The block decodes it into the timing registers and a control register, which selects pixel rate, colour depth and interlace. From the two axis states the block forms the phase of the current line: sync, blank, border or display. In interlaced mode it also forms two special half-sync lines. It provides line-start and display-start strobes and a sticky flyback interrupt that the CPU clears.

Pixel fetch and pixel generation are done by a downstream stage. That stage uses `phase`, the display-active flags, `pix_rate` and `colour_depth`. All pins are plain level or pulse signals. No pin carries a data stream, so the block has no handshake.

Top module: `raster_timing_gen`

## Requirements
- R1: When `wr_en` is high, `wr_data[31:26]` selects the target and `wr_data[23:14]` holds the 10-bit value.
  - Horizontal targets: 0x20 period, 0x21 sync width, 0x22 border begin, 0x23 display begin, 0x24 display finish, 0x25 border finish.
  - Vertical targets: 0x28 to 0x2D, in the same order.
  - 0x27 holds the half-line sync point.
  - 0x38 is the control register: pixel rate in bits 1:0 (shown on `pix_rate`), colour depth in bits 3:2 (shown on `colour_depth`), interlace enable in bit 6.
  - Every other target, and all other bits, have no effect.
- R2: Positions change only on a clock edge where `tick` is high. The horizontal position steps by one. The vertical position steps once per horizontal restart. A new register value is used from the next tick.
- R3: On a tick where the position equals the period, the position returns to 0 and every event flag of that axis clears. Otherwise a tick that sees position equal to a compare value sets that flag, and the flag stays set until the next restart.
- R4: `line_start` is high for exactly the one cycle after a tick that restarted the horizontal axis.
- R5: The axis phase is computed in this order:
  - sync until sync-ended is set;
  - otherwise blank if border-begin is not yet set or border-finish is set;
  - otherwise border if display-begin is not yet set or display-finish is set;
  - otherwise display.
  - `phase` is encoded as 0 sync, 1 blank, 2 border, 3 display.
- R6: `h_disp_active` and `v_disp_active` are each high when that axis has display-begin set and display-finish clear.
- R7: The line phase depends on the vertical phase:
  - on vertical-sync lines `phase` is sync for the whole line;
  - on vertical-blank lines it is sync until horizontal sync ends and blank after that;
  - on vertical-border lines the horizontal phase is shown with display replaced by border;
  - on vertical-display lines the horizontal phase is shown as is.
- R8: With interlace enabled, the vertical restart into every odd field makes the next line a start-half-sync line. On that line the output is sync until horizontal sync ends, then blank, then sync again from the point where the horizontal position equals the half-line sync point (matched after sync has ended) to the end of the line.
- R9: With interlace enabled, during the odd field the vertical counter stays on its value for one extra line the first time it reaches the sync width. That extra line is an end-half-sync line: sync until the horizontal position equals the half-line sync point, blank after that.
- R10: `flyback_irq` is set in the cycle after the vertical phase leaves display. It stays set until `irq_ack` is high. If a set and `irq_ack` occur in the same cycle, the set wins.
- R11: `frame_disp_start` is high for one cycle when the vertical phase enters display.
- R12: The counter runs modulo 1024. If the period is lowered below the current position, the counter runs through 1023 and 0 and restarts when it next equals the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Half-pixel timing enable |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write word: target code and value |
| irq_ack | input | 1 | Clears the flyback interrupt |
| phase | output | 2 | Line phase: 0 sync, 1 blank, 2 border, 3 display |
| h_disp_active | output | 1 | Horizontal display window active |
| v_disp_active | output | 1 | Vertical display window active |
| line_start | output | 1 | One-cycle pulse after a horizontal restart |
| frame_disp_start | output | 1 | One-cycle pulse when the vertical display begins |
| flyback_irq | output | 1 | Sticky flyback interrupt |
| pix_rate | output | 2 | Programmed pixel-rate select |
| colour_depth | output | 2 | Programmed colour depth |

## Verification
The bench checks every line of a full frame, including the lines where a collapse of display into border gives a different result. A design that mixed up the vertical and horizontal fallbacks would show display pixels on border lines. The interlace run counts the lines of the odd field. If the counter were not held at the sync width, the display would start one line early and no end-half-sync line would appear. If the half-sync point were not latched, the output would fall back to blank after that point. The bench lowers the period below the running position and measures the 1020 ticks until the next restart. A design that compared with "greater or equal" would restart at once. Two irq checks, an acknowledge alone and an acknowledge in the cycle of the set, catch a priority given the wrong way round.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int POS_W   = 10;
  localparam int DATA_W  = 32;
  localparam int TGT_W   = 6;
  localparam int VAL_LSB = 14;

  localparam logic [2:0]       GRP_HORZ   = 3'b100;
  localparam logic [2:0]       GRP_VERT   = 3'b101;
  localparam logic [TGT_W-1:0] TGT_HALFSY = 6'h27;
  localparam logic [TGT_W-1:0] TGT_CTRL   = 6'h38;

  localparam logic [2:0] OFS_PERIOD  = 3'd0;
  localparam logic [2:0] OFS_SYNC    = 3'd1;
  localparam logic [2:0] OFS_BRD_BEG = 3'd2;
  localparam logic [2:0] OFS_DSP_BEG = 3'd3;
  localparam logic [2:0] OFS_DSP_FIN = 3'd4;
  localparam logic [2:0] OFS_BRD_FIN = 3'd5;

  typedef enum logic [1:0] {PH_SYNC = 2'd0, PH_BLANK = 2'd1, PH_BORDER = 2'd2, PH_DISP = 2'd3} phase_e;
  typedef enum logic [2:0] {VL_SYNC, VL_BLANK, VL_BORDER, VL_DISP, VL_HSTART, VL_HEND} vline_e;
  typedef enum logic [1:0] {OV_NONE, OV_START, OV_END} ovr_e;

  typedef struct packed {
    logic sync_done;
    logic brd_on;
    logic brd_off;
    logic dsp_on;
    logic dsp_off;
  } evt_t;

  typedef struct packed {
    logic [POS_W-1:0] period;
    logic [POS_W-1:0] sync_w;
    logic [POS_W-1:0] brd_beg;
    logic [POS_W-1:0] dsp_beg;
    logic [POS_W-1:0] dsp_fin;
    logic [POS_W-1:0] brd_fin;
  } axis_cfg_t;

  function automatic phase_e evt_phase(evt_t e);
    if (!e.sync_done)               return PH_SYNC;
    if (!e.brd_on || e.brd_off)     return PH_BLANK;
    if (!e.dsp_on || e.dsp_off)     return PH_BORDER;
    return PH_DISP;
  endfunction
endpackage

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output axis_cfg_t         h_cfg,
  output axis_cfg_t         v_cfg,
  output logic [POS_W-1:0]  halfsync_pos,
  output logic [1:0]        pix_rate,
  output logic [1:0]        colour_depth,
  output logic              il_en
);
  logic [TGT_W-1:0] tgt;
  logic [POS_W-1:0] val;
  logic             unused_bits;

  assign tgt = wr_data[DATA_W-1 -: TGT_W];
  assign val = wr_data[VAL_LSB +: POS_W];
  assign unused_bits = ^{wr_data[DATA_W-TGT_W-1:VAL_LSB+POS_W], wr_data[VAL_LSB-1:7], wr_data[5:4]};

  for (genvar a = 0; a < 2; a++) begin : g_axis
    localparam logic [2:0] GRP = (a == 0) ? GRP_HORZ : GRP_VERT;
    axis_cfg_t cfg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
      end else if (wr_en && tgt[5:3] == GRP) begin
        case (tgt[2:0])
          OFS_PERIOD:  cfg_q.period  <= val;
          OFS_SYNC:    cfg_q.sync_w  <= val;
          OFS_BRD_BEG: cfg_q.brd_beg <= val;
          OFS_DSP_BEG: cfg_q.dsp_beg <= val;
          OFS_DSP_FIN: cfg_q.dsp_fin <= val;
          OFS_BRD_FIN: cfg_q.brd_fin <= val;
          default: ;
        endcase
      end
    end
  end

  assign h_cfg = g_axis[0].cfg_q;
  assign v_cfg = g_axis[1].cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halfsync_pos <= '0;
      pix_rate     <= '0;
      colour_depth <= '0;
      il_en        <= 1'b0;
    end else if (wr_en) begin
      if (tgt == TGT_HALFSY) halfsync_pos <= val;
      if (tgt == TGT_CTRL) begin
        pix_rate     <= wr_data[1:0];
        colour_depth <= wr_data[3:2];
        il_en        <= wr_data[6];
      end
    end
  end
endmodule

// File: rtl/raster_axis.sv
module raster_axis
  import raster_pkg::*;
#(
  parameter bit IS_VERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  axis_cfg_t        cfg,
  input  logic             il_en,
  output logic [POS_W-1:0] pos,
  output evt_t             evt,
  output ovr_e             ovr,
  output logic             wrap
);
  logic [POS_W-1:0] pos_q;
  evt_t             evt_q;
  evt_t             hits;
  ovr_e             ovr_q;
  logic             odd_q;
  logic             at_end;
  logic             hold;

  assign at_end = (pos_q == cfg.period);
  assign hits.sync_done = (pos_q == cfg.sync_w);
  assign hits.brd_on    = (pos_q == cfg.brd_beg);
  assign hits.brd_off   = (pos_q == cfg.brd_fin);
  assign hits.dsp_on    = (pos_q == cfg.dsp_beg);
  assign hits.dsp_off   = (pos_q == cfg.dsp_fin);

  // Odd field: stall once at the sync width to insert the end-half-sync line.
  assign hold = IS_VERT && il_en && odd_q && (ovr_q == OV_NONE) && hits.sync_done && !at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      evt_q <= '0;
      ovr_q <= OV_NONE;
      odd_q <= 1'b0;
    end else if (step) begin
      evt_q <= evt_q | hits;
      ovr_q <= hold ? OV_END : OV_NONE;
      if (at_end) begin
        evt_q <= '0;
        pos_q <= '0;
        odd_q <= ~odd_q;
        if (IS_VERT && il_en && !odd_q) ovr_q <= OV_START;
      end else if (!hold) begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign pos  = pos_q;
  assign evt  = evt_q;
  assign ovr  = ovr_q;
  assign wrap = step && at_end;

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pos_q));
  assert_restart_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_end) |=> (pos_q == '0 && evt_q == '0));
endmodule

// File: rtl/raster_phase.sv
module raster_phase
  import raster_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             h_wrap,
  input  vline_e           vl,
  input  evt_t             h_evt,
  input  logic [POS_W-1:0] h_pos,
  input  logic [POS_W-1:0] halfsync_pos,
  output phase_e           ph
);
  logic   seen_q;
  logic   match_now;
  logic   hit;
  phase_e hph;

  // On a start-half-sync line the switch point only counts once sync has ended.
  assign match_now = (h_pos == halfsync_pos) && ((vl != VL_HSTART) || h_evt.sync_done);
  assign hit       = seen_q | match_now;
  assign hph       = evt_phase(h_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seen_q <= 1'b0;
    else if (step) seen_q <= h_wrap ? 1'b0 : hit;
  end

  always_comb begin
    case (vl)
      VL_SYNC:   ph = PH_SYNC;
      VL_BLANK:  ph = h_evt.sync_done ? PH_BLANK : PH_SYNC;
      VL_HSTART: ph = (!h_evt.sync_done || hit) ? PH_SYNC : PH_BLANK;
      VL_HEND:   ph = hit ? PH_BLANK : PH_SYNC;
      VL_BORDER: ph = (hph == PH_DISP) ? PH_BORDER : hph;
      default:   ph = hph;
    endcase
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        irq_ack,
  output logic [1:0]  phase,
  output logic        h_disp_active,
  output logic        v_disp_active,
  output logic        line_start,
  output logic        frame_disp_start,
  output logic        flyback_irq,
  output logic [1:0]  pix_rate,
  output logic [1:0]  colour_depth
);
  axis_cfg_t        h_cfg, v_cfg;
  logic [POS_W-1:0] halfsync_pos;
  logic             il_en;
  logic [POS_W-1:0] h_pos;
  logic [POS_W-1:0] v_pos_unused;
  evt_t             h_evt, v_evt;
  ovr_e             h_ovr_unused, v_ovr;
  logic             h_wrap, v_wrap_unused;
  vline_e           vl, vl_last;
  phase_e           ph;
  logic             line_start_q;
  logic             irq_q;

  raster_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .h_cfg(h_cfg), .v_cfg(v_cfg), .halfsync_pos(halfsync_pos),
    .pix_rate(pix_rate), .colour_depth(colour_depth), .il_en(il_en)
  );

  raster_axis #(.IS_VERT(1'b0)) u_h_axis (
    .clk(clk), .rst_n(rst_n), .step(tick), .cfg(h_cfg), .il_en(1'b0),
    .pos(h_pos), .evt(h_evt), .ovr(h_ovr_unused), .wrap(h_wrap)
  );

  raster_axis #(.IS_VERT(1'b1)) u_v_axis (
    .clk(clk), .rst_n(rst_n), .step(h_wrap), .cfg(v_cfg), .il_en(il_en),
    .pos(v_pos_unused), .evt(v_evt), .ovr(v_ovr), .wrap(v_wrap_unused)
  );

  always_comb begin
    case (v_ovr)
      OV_START: vl = VL_HSTART;
      OV_END:   vl = VL_HEND;
      default: begin
        case (evt_phase(v_evt))
          PH_SYNC:   vl = VL_SYNC;
          PH_BLANK:  vl = VL_BLANK;
          PH_BORDER: vl = VL_BORDER;
          default:   vl = VL_DISP;
        endcase
      end
    endcase
  end

  raster_phase u_phase (
    .clk(clk), .rst_n(rst_n), .step(tick), .h_wrap(h_wrap), .vl(vl),
    .h_evt(h_evt), .h_pos(h_pos), .halfsync_pos(halfsync_pos), .ph(ph)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_last      <= VL_SYNC;
      line_start_q <= 1'b0;
      irq_q        <= 1'b0;
    end else begin
      vl_last      <= vl;
      line_start_q <= h_wrap;
      if (vl_last == VL_DISP && vl != VL_DISP) irq_q <= 1'b1;
      else if (irq_ack)                        irq_q <= 1'b0;
    end
  end

  assign phase            = ph;
  assign h_disp_active    = h_evt.dsp_on & ~h_evt.dsp_off;
  assign v_disp_active    = v_evt.dsp_on & ~v_evt.dsp_off;
  assign line_start       = line_start_q;
  assign frame_disp_start = (vl == VL_DISP) && (vl_last != VL_DISP);
  assign flyback_irq      = irq_q;

  assert_line_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> (h_pos == '0));
  assert_frame_in_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_disp_start |-> v_disp_active);
  assert_irq_outside_display_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flyback_irq) |-> (vl != VL_DISP));
endmodule

// File: tb/raster_timing_gen_test.sv
`timescale 1ns/1ps
module raster_timing_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        irq_ack = 1'b0;
  logic [1:0]  phase;
  logic        h_disp_active, v_disp_active, line_start, frame_disp_start, flyback_irq;
  logic [1:0]  pix_rate, colour_depth;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  raster_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .irq_ack(irq_ack), .phase(phase), .h_disp_active(h_disp_active),
    .v_disp_active(v_disp_active), .line_start(line_start),
    .frame_disp_start(frame_disp_start), .flyback_irq(flyback_irq),
    .pix_rate(pix_rate), .colour_depth(colour_depth)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [5:0] tgt, input logic [9:0] val, input logic [13:0] low);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = {tgt, 2'b11, val, low};
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic do_reset();
    tick = 1'b0; wr_en = 1'b0; irq_ack = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic prog_horz();
    wr(6'h20, 10'd9, 14'h3fff);
    wr(6'h21, 10'd1, 14'h0);
    wr(6'h22, 10'd2, 14'h0);
    wr(6'h23, 10'd3, 14'h0);
    wr(6'h24, 10'd7, 14'h0);
    wr(6'h25, 10'd8, 14'h0);
  endtask

  // Expected line phase for horizontal {9,1,2,3,7,8} and vertical {7,0,1,2,5,6}.
  function automatic int exp_phase(int h, int v);
    int hp, vp;
    hp = (h < 2) ? 0 : (h < 3) ? 1 : (h < 4) ? 2 : (h < 8) ? 3 : (h < 9) ? 2 : 1;
    vp = (v < 1) ? 0 : (v < 2) ? 1 : (v < 3) ? 2 : (v < 6) ? 3 : (v < 7) ? 2 : 1;
    case (vp)
      0: return 0;
      1: return (h < 2) ? 0 : 1;
      2: return (hp == 3) ? 2 : hp;
      default: return hp;
    endcase
  endfunction

  task automatic t_reset();
    do_reset();
    chk("R5 reset phase", phase, 0);
    chk("R6 reset h_disp", h_disp_active, 0);
    chk("R6 reset v_disp", v_disp_active, 0);
    chk("R4 reset line_start", line_start, 0);
    chk("R10 reset irq", flyback_irq, 0);
    chk("R1 reset pix_rate", pix_rate, 0);
  endtask

  task automatic t_decode_and_frame();
    bit exp_irq;
    do_reset();
    prog_horz();
    wr(6'h28, 10'd7, 14'h0);
    wr(6'h29, 10'd0, 14'h0);
    wr(6'h2A, 10'd1, 14'h0);
    wr(6'h2B, 10'd2, 14'h0);
    wr(6'h2C, 10'd5, 14'h0);
    wr(6'h2D, 10'd6, 14'h0);
    wr(6'h2E, 10'd0, 14'h0);      // R1: unmapped code, ignored
    wr(6'h3F, 10'h3ff, 14'h3fff); // R1: unmapped code, ignored
    wr(6'h38, 10'd0, 14'h0006);
    chk("R1 pix_rate", pix_rate, 2);
    chk("R1 colour_depth", colour_depth, 1);
    exp_irq = 1'b0;
    tick = 1'b1;
    for (int k = 1; k <= 160; k++) begin
      int h, v;
      @(negedge clk);
      h = k % 10;
      v = (k / 10) % 8;
      if (h == 1 && v == 6) exp_irq = 1'b1;
      chk("R7 line phase", phase, exp_phase(h, v));
      chk("R6 h_disp", h_disp_active, (h >= 4 && h <= 7));
      chk("R6 v_disp", v_disp_active, (v >= 3 && v <= 5));
      chk("R4 line_start", line_start, (h == 0));
      chk("R11 frame_disp_start", frame_disp_start, (h == 0 && v == 3));
      chk("R10 irq sticky", flyback_irq, exp_irq);
      if (k == 45) begin
        tick = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 phase held without tick", phase, 3);
        chk("R2 h_disp held without tick", h_disp_active, 1);
        tick = 1'b1;
      end
    end
  endtask

  task automatic t_irq();
    // Continues from frame state k=160 with irq set.
    tick = 1'b0;
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R10 ack clears", flyback_irq, 0);
    tick = 1'b1;
    repeat (60) @(negedge clk);
    chk("R10 not yet set", flyback_irq, 0);
    irq_ack = 1'b1;
    @(negedge clk);
    chk("R10 set beats ack", flyback_irq, 1);
    tick = 1'b0;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R10 second ack clears", flyback_irq, 0);
  endtask

  task automatic t_interlace();
    do_reset();
    prog_horz();
    wr(6'h27, 10'd5, 14'h0);
    wr(6'h28, 10'd7, 14'h0);
    wr(6'h29, 10'd1, 14'h0);
    wr(6'h2A, 10'd2, 14'h0);
    wr(6'h2B, 10'd3, 14'h0);
    wr(6'h2C, 10'd5, 14'h0);
    wr(6'h2D, 10'd6, 14'h0);
    wr(6'h38, 10'd0, 14'h0040);
    tick = 1'b1;
    for (int k = 1; k <= 175; k++) begin
      int h, ln, e;
      @(negedge clk);
      h = k % 10;
      chk("R9 frame_disp_start timing", frame_disp_start, (k == 40 || k == 130));
      if (k >= 80 && k < 120) begin
        ln = (k - 80) / 10;
        case (ln)
          0: e = (h < 2 || h >= 5) ? 0 : 1;
          1: e = 0;
          2: e = (h < 5) ? 0 : 1;
          default: e = (h < 2) ? 0 : 1;
        endcase
        if (ln == 0)      chk("R8 start-half-sync line", phase, e);
        else if (ln == 2) chk("R9 end-half-sync line", phase, e);
        else              chk("R9 odd field line", phase, e);
      end
      if (k >= 170) chk("R8 even field first line", phase, 0);
    end
  endtask

  task automatic t_shrink();
    int got;
    do_reset();
    prog_horz();
    tick = 1'b1;
    repeat (8) @(negedge clk);
    tick = 1'b0;
    wr(6'h20, 10'd3, 14'h0);
    got = -1;
    tick = 1'b1;
    for (int n = 1; n <= 1100; n++) begin
      @(negedge clk);
      if (line_start) begin
        got = n;
        break;
      end
    end
    tick = 1'b0;
    chk("R12 restart after 1024 wrap", got, 1020);
  endtask

  initial begin
    t_reset();
    t_decode_and_frame();
    t_irq();
    t_interlace();
    t_shrink();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule